// File: doc/BRIEF.md
# Interlaced Video Sync Timing Generator

This block produces the line and field timing for an interlaced composite video encoder. A pixel counter runs along each line, and a line counter runs down each field. An odd/even flag alternates between two fields of different length. From these counters the block derives horizontal sync, vertical sync, composite blanking and the field flag. It also gives downstream encoding logic a two-bit output-level select. The select tells that logic whether to emit picture, front-porch, blanking or sync level.

The block runs in one of two modes. As timing master it drives all four timing pins from its own counters, and it ignores the external sync inputs. As a slave it receives horizontal sync, vertical sync and blanking from outside. Each of these passes through a two-flop synchronizer, a polarity correction and a leading-edge detector. The block then realigns its counters to each detected edge. A sync edge that comes before the counter reaches its end cuts the interval short. When the counter reaches its end before the edge arrives, it stops there and holds the output level until the edge comes. A line holds at front-porch level; a field holds at blanking level. Each timing pin has its own polarity bit. Because the sync pins are shared between the two modes, the block gives an output-enable for them.

Top module: `vid_sync_gen`

## Requirements
- R1: While reset is asserted, the pixel and line counters read 0, the field flag is 0 (field_o equals pol_field_i), and level_o is 3 (sync).
- R2: In master mode, the pixel counter runs 0 to LINE_LEN-1 and wraps. The line counter advances on each wrap. hs_i, vs_i and blank_i have no effect.
- R3: In master mode, a field with flag 0 lasts ODD_LINES lines and a field with flag 1 lasts EVEN_LINES lines. The flag toggles when the line counter returns to 0.
- R4: The raw horizontal sync is pixel < HS_W. The raw vertical sync is line < VS_LINES. The raw blanking is pixel < ACT_START, pixel >= ACT_START+ACT_W, or line < VBLANK_LINES. Each pin equals its raw value XOR its polarity bit. drive_o is 1 in master mode and 0 in slave mode.
- R5: level_o encodes 0 = active, 1 = front porch, 2 = blanking, 3 = sync. The priority from highest to lowest is: field hold (2), then a vertical or horizontal sync region (3), then line hold (1), then vertical blanking, horizontal blanking or external blank (2), then pixel >= ACT_START+ACT_W (1), and otherwise active (0).
- R6: In slave mode, a horizontal sync edge that comes before the line end starts a new line early. The pixel counter reads 0 three clock edges after the first edge that samples the input asserted, and the line counter advances.
- R7: In slave mode, a pixel counter that reaches LINE_LEN-1 stays there with level_o = 1 in active lines until the next horizontal sync edge. The line length therefore equals the spacing between sync edges.
- R8: In slave mode, a vertical sync edge that comes before the field end sets the line counter to 0 and toggles the field flag.
- R9: In slave mode, a line counter that reaches the last line of its field stays there with level_o = 2 until a vertical sync edge. The edge then sets the line counter to 0 and toggles the field flag.
- R10: When a horizontal and a vertical sync edge are detected in the same cycle, the line counter goes to 0, not to line+1, and the pixel counter also restarts at 0.
- R11: In slave mode, an asserted external blank input forces level_o to 2 where it would otherwise be 0 or 1.
- R12: A polarity bit of 1 makes its input active-low. Realignment happens on the transition into the asserted state after correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_i | input | 1 | 1 = follow external syncs, 0 = generate timing |
| pol_hs_i | input | 1 | Horizontal sync polarity, 1 = active low |
| pol_vs_i | input | 1 | Vertical sync polarity, 1 = active low |
| pol_blank_i | input | 1 | Blanking polarity, 1 = active low |
| pol_field_i | input | 1 | Field flag polarity, 1 = inverted |
| hs_i | input | 1 | External horizontal sync (slave mode) |
| vs_i | input | 1 | External vertical sync (slave mode) |
| blank_i | input | 1 | External composite blanking (slave mode) |
| hs_o | output | 1 | Generated horizontal sync |
| vs_o | output | 1 | Generated vertical sync |
| blank_o | output | 1 | Generated composite blanking |
| field_o | output | 1 | Odd/even field flag |
| drive_o | output | 1 | Output enable for the shared sync pins |
| pix_cnt_o | output | PIX_W | Pixel position in line |
| line_cnt_o | output | LINE_W | Line position in field |
| level_o | output | 2 | Output-level select |

## Verification
The case that needs the most care is a slave-mode vertical sync edge that lands in the same cycle as a horizontal sync edge. Here the end of a line and the realignment of the field both act on the line counter together. The bench provokes it by pulsing both external inputs on the same clock. It then judges the result at the ports: the line counter must read 0 rather than the advanced line, the pixel counter must restart, and the field flag must toggle. A second kind of overlap is a line hold during a field hold. Here the field-hold blanking level must win, and this is checked during a late vertical sync.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    LVL_ACTIVE = 2'd0,
    LVL_FPORCH = 2'd1,
    LVL_BLANK  = 2'd2,
    LVL_SYNC   = 2'd3
  } level_e;
endpackage

// File: rtl/vsg_sync_in.sv
module vsg_sync_in (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic edge_o
);
  logic [1:0] meta_q;
  logic       prev_q;
  logic       lvl;

  assign lvl = meta_q[1] ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      prev_q <= 1'b1;  // no edge right after reset
    end else begin
      meta_q <= {meta_q[0], raw_i};
      prev_q <= lvl;
    end
  end

  assign lvl_o  = lvl;
  assign edge_o = lvl & ~prev_q;
endmodule

// File: rtl/vsg_hcount.sv
module vsg_hcount #(
  parameter int unsigned LINE_LEN = 858,
  parameter int unsigned PIX_W    = $clog2(LINE_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_i,
  input  logic             realign_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             hold_o,
  output logic             line_end_o
);
  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_LEN - 1);

  logic [PIX_W-1:0] pix_q;
  logic             hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q  <= '0;
      hold_q <= 1'b0;
    end else if (slave_i && realign_i) begin
      pix_q  <= '0;
      hold_q <= 1'b0;
    end else if (pix_q == PIX_LAST) begin
      if (slave_i) begin
        hold_q <= 1'b1;  // late sync: park at line end
      end else begin
        pix_q  <= '0;
        hold_q <= 1'b0;
      end
    end else begin
      pix_q  <= pix_q + 1'b1;
      hold_q <= 1'b0;
    end
  end

  assign pix_o      = pix_q;
  assign hold_o     = hold_q;
  assign line_end_o = slave_i ? realign_i : (pix_q == PIX_LAST);
endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount #(
  parameter int unsigned ODD_LINES  = 263,
  parameter int unsigned EVEN_LINES = 262,
  parameter int unsigned LINE_W     = $clog2(ODD_LINES > EVEN_LINES ? ODD_LINES : EVEN_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_i,
  input  logic              line_end_i,
  input  logic              realign_i,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic              hold_o
);
  localparam logic [LINE_W-1:0] ODD_LAST  = LINE_W'(ODD_LINES - 1);
  localparam logic [LINE_W-1:0] EVEN_LAST = LINE_W'(EVEN_LINES - 1);

  logic [LINE_W-1:0] line_q;
  logic              field_q;
  logic              hold_q;
  logic [LINE_W-1:0] last_line;

  assign last_line = field_q ? EVEN_LAST : ODD_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      field_q <= 1'b0;
      hold_q  <= 1'b0;
    end else if (slave_i && realign_i) begin
      // vertical realign wins over a same-cycle line end
      line_q  <= '0;
      field_q <= ~field_q;
      hold_q  <= 1'b0;
    end else if (line_end_i) begin
      if (line_q == last_line) begin
        if (slave_i) begin
          hold_q <= 1'b1;
        end else begin
          line_q  <= '0;
          field_q <= ~field_q;
        end
      end else begin
        line_q <= line_q + 1'b1;
      end
    end
  end

  assign line_o  = line_q;
  assign field_o = field_q;
  assign hold_o  = hold_q;
endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen #(
  parameter int unsigned LINE_LEN     = 858,
  parameter int unsigned HS_W         = 64,
  parameter int unsigned ACT_START    = 122,
  parameter int unsigned ACT_W        = 720,
  parameter int unsigned ODD_LINES    = 263,
  parameter int unsigned EVEN_LINES   = 262,
  parameter int unsigned VS_LINES     = 3,
  parameter int unsigned VBLANK_LINES = 20,
  parameter int unsigned PIX_W        = $clog2(LINE_LEN),
  parameter int unsigned LINE_W       = $clog2(ODD_LINES > EVEN_LINES ? ODD_LINES : EVEN_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_i,
  input  logic              pol_hs_i,
  input  logic              pol_vs_i,
  input  logic              pol_blank_i,
  input  logic              pol_field_i,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic              blank_i,
  output logic              hs_o,
  output logic              vs_o,
  output logic              blank_o,
  output logic              field_o,
  output logic              drive_o,
  output logic [PIX_W-1:0]  pix_cnt_o,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic [1:0]        level_o
);
  import vsg_pkg::*;

  localparam int unsigned N_EXT = 3;
  localparam int unsigned IDX_HS = 0;
  localparam int unsigned IDX_VS = 1;
  localparam int unsigned IDX_BL = 2;
  localparam logic [PIX_W-1:0]  HS_END  = PIX_W'(HS_W);
  localparam logic [PIX_W-1:0]  ACT_BEG = PIX_W'(ACT_START);
  localparam logic [PIX_W-1:0]  ACT_END = PIX_W'(ACT_START + ACT_W);
  localparam logic [LINE_W-1:0] VS_END  = LINE_W'(VS_LINES);
  localparam logic [LINE_W-1:0] VB_END  = LINE_W'(VBLANK_LINES);

  logic [N_EXT-1:0] ext_raw, ext_pol, ext_lvl, ext_edge;

  assign ext_raw = {blank_i, vs_i, hs_i};
  assign ext_pol = {pol_blank_i, pol_vs_i, pol_hs_i};

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    vsg_sync_in u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (ext_raw[g]),
      .pol_i  (ext_pol[g]),
      .lvl_o  (ext_lvl[g]),
      .edge_o (ext_edge[g])
    );
  end

  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;
  logic              h_hold, v_hold, field_q, line_end;

  vsg_hcount #(.LINE_LEN(LINE_LEN), .PIX_W(PIX_W)) u_h (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slave_i    (slave_i),
    .realign_i  (ext_edge[IDX_HS]),
    .pix_o      (pix),
    .hold_o     (h_hold),
    .line_end_o (line_end)
  );

  vsg_vcount #(.ODD_LINES(ODD_LINES), .EVEN_LINES(EVEN_LINES), .LINE_W(LINE_W)) u_v (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slave_i    (slave_i),
    .line_end_i (line_end),
    .realign_i  (ext_edge[IDX_VS]),
    .line_o     (line),
    .field_o    (field_q),
    .hold_o     (v_hold)
  );

  logic in_hsync, in_vsync, in_hblank, in_vblank, ext_blank;
  level_e lvl;

  assign in_hsync  = pix < HS_END;
  assign in_vsync  = line < VS_END;
  assign in_hblank = (pix < ACT_BEG) || (pix >= ACT_END);
  assign in_vblank = line < VB_END;
  assign ext_blank = slave_i && ext_lvl[IDX_BL];

  always_comb begin
    if (v_hold)                                      lvl = LVL_BLANK;
    else if (in_vsync || in_hsync)                   lvl = LVL_SYNC;
    else if (h_hold)                                 lvl = LVL_FPORCH;
    else if (in_vblank || pix < ACT_BEG || ext_blank) lvl = LVL_BLANK;
    else if (pix >= ACT_END)                         lvl = LVL_FPORCH;
    else                                             lvl = LVL_ACTIVE;
  end

  assign hs_o       = in_hsync ^ pol_hs_i;
  assign vs_o       = in_vsync ^ pol_vs_i;
  assign blank_o    = (in_hblank || in_vblank) ^ pol_blank_i;
  assign field_o    = field_q ^ pol_field_i;
  assign drive_o    = ~slave_i;
  assign pix_cnt_o  = pix;
  assign line_cnt_o = line;
  assign level_o    = lvl;
endmodule

// File: rtl/vsg_sync_gen_chk.sv
module vsg_sync_gen_chk #(
  parameter int unsigned LINE_LEN     = 858,
  parameter int unsigned ACT_START    = 122,
  parameter int unsigned ACT_W        = 720,
  parameter int unsigned VBLANK_LINES = 20,
  parameter int unsigned PIX_W        = 10,
  parameter int unsigned LINE_W       = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slave_i,
  input logic [PIX_W-1:0]  pix_i,
  input logic [LINE_W-1:0] line_i,
  input logic [1:0]        level_i,
  input logic              h_hold_i,
  input logic              v_hold_i,
  input logic              field_i
);
  localparam logic [PIX_W-1:0]  LAST    = PIX_W'(LINE_LEN - 1);
  localparam logic [PIX_W-1:0]  ACT_BEG = PIX_W'(ACT_START);
  localparam logic [PIX_W-1:0]  ACT_END = PIX_W'(ACT_START + ACT_W);
  localparam logic [LINE_W-1:0] VB_END  = LINE_W'(VBLANK_LINES);

  AST_PIX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_i <= LAST); // R2
  AST_MASTER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_i && pix_i == LAST) |=> (slave_i || pix_i == '0)); // R2
  AST_FIELD_AT_LINE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_i != $past(field_i)) |-> (line_i == '0)); // R3
  AST_ACTIVE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == 2'd0) |-> (pix_i >= ACT_BEG && pix_i < ACT_END && line_i >= VB_END)); // R5
  AST_HHOLD_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_hold_i |-> (slave_i && pix_i == LAST && level_i != 2'd0)); // R7
  AST_HHOLD_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_hold_i && slave_i) |=> (pix_i == LAST || pix_i == '0)); // R7
  AST_VHOLD_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_hold_i |-> (level_i == 2'd2)); // R9
  AST_VHOLD_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_hold_i && slave_i) |=> ($stable(line_i) || line_i == '0)); // R9
endmodule

bind vid_sync_gen vsg_sync_gen_chk #(
  .LINE_LEN     (LINE_LEN),
  .ACT_START    (ACT_START),
  .ACT_W        (ACT_W),
  .VBLANK_LINES (VBLANK_LINES),
  .PIX_W        (PIX_W),
  .LINE_W       (LINE_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .slave_i  (slave_i),
  .pix_i    (pix_cnt_o),
  .line_i   (line_cnt_o),
  .level_i  (level_o),
  .h_hold_i (h_hold),
  .v_hold_i (v_hold),
  .field_i  (field_q)
);

// File: tb/sim_vid_sync_gen.sv
module sim_vid_sync_gen;
  localparam int LL = 24, HSW = 3, ACS = 6, ACW = 14;
  localparam int ODD = 12, EVEN = 11, VSL = 1, VBL = 2;
  localparam int PW = $clog2(LL), LW = $clog2(ODD);

  typedef struct packed { int gap; int len; int hold; } hvec_t;
  localparam hvec_t HTAB [6] = '{
    '{24, 24, 1}, '{16, 16, 0}, '{31, 31, 8},
    '{9,  9,  0}, '{24, 24, 1}, '{40, 40, 17}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, slave, p_hs, p_vs, p_bl, p_fd, hs_i, vs_i, blank_i;
  logic hs_o, vs_o, blank_o, field_o, drive_o;
  logic [PW-1:0] pix;
  logic [LW-1:0] line;
  logic [1:0]    level;

  vid_sync_gen #(
    .LINE_LEN(LL), .HS_W(HSW), .ACT_START(ACS), .ACT_W(ACW),
    .ODD_LINES(ODD), .EVEN_LINES(EVEN), .VS_LINES(VSL), .VBLANK_LINES(VBL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .slave_i(slave),
    .pol_hs_i(p_hs), .pol_vs_i(p_vs), .pol_blank_i(p_bl), .pol_field_i(p_fd),
    .hs_i(hs_i), .vs_i(vs_i), .blank_i(blank_i),
    .hs_o(hs_o), .vs_o(vs_o), .blank_o(blank_o), .field_o(field_o),
    .drive_o(drive_o), .pix_cnt_o(pix), .line_cnt_o(line), .level_o(level)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic hs_on = 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // line-length and hold monitor on the ports
  int cyc = 0, last_start = 0, last_len = 0, last_hold = 0, last_bad = 0;
  int hold_cnt = 0, hold_bad = 0, prev_pix = 0;
  always @(negedge clk) begin
    cyc++;
    if (pix == 0 && prev_pix != 0) begin
      last_len = cyc - last_start; last_start = cyc;
      last_hold = hold_cnt; last_bad = hold_bad;
      hold_cnt = 0; hold_bad = 0;
    end
    if (int'(pix) == LL - 1) begin
      hold_cnt++;
      if (int'(line) >= VBL && level != 2'd1) hold_bad = 1;
    end
    prev_pix = int'(pix);
  end

  function automatic int exp_level(input int p, input int l);
    if (l < VSL || p < HSW) return 3;
    if (l < VBL || p < ACS) return 2;
    if (p >= ACS + ACW) return 1;
    return 0;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  // pulse starts at the current negedge, returns 4 negedges later
  task automatic pulse(input bit h, input bit v);
    if (h) hs_i = hs_on;
    if (v) vs_i = 1'b1;
    @(negedge clk); @(negedge clk);
    hs_i = ~hs_on; vs_i = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic hpulses(input int n);
    for (int i = 0; i < n; i++) begin pulse(1, 0); repeat (20) @(negedge clk); end
  endtask

  initial begin
    rst_n = 1'b0; slave = 1'b0;
    p_hs = 1'b1; p_vs = 1'b0; p_bl = 1'b1; p_fd = 1'b1;
    hs_i = 1'b0; vs_i = 1'b0; blank_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pix", int'(pix), 0);
    chk("R1 line", int'(line), 0);
    chk("R1 level", int'(level), 3);
    chk("R1 field", int'(field_o), 1);
    rst_n = 1'b1;

    // master mode over two frames, with toggling external inputs
    for (int t = 1; t <= 2 * (ODD + EVEN) * LL; t++) begin
      int ep, lt, ef, el;
      @(negedge clk);
      ep = t % LL;
      lt = (t / LL) % (ODD + EVEN);
      ef = (lt >= ODD) ? 1 : 0;
      el = ef ? lt - ODD : lt;
      chk("R2 pix", int'(pix), ep);
      chk("R2 line", int'(line), el);
      chk("R3 field", int'(field_o), ef ^ 1);
      chk("R4 hs", int'(hs_o), int'(ep < HSW) ^ 1);
      chk("R4 vs", int'(vs_o), int'(el < VSL));
      chk("R4 blank", int'(blank_o), int'(ep < ACS || ep >= ACS + ACW || el < VBL) ^ 1);
      chk("R4 drive", int'(drive_o), 1);
      chk("R5 level", int'(level), exp_level(ep, el));
      hs_i = t[1]; vs_i = t[3]; blank_i = t[2];
    end

    // slave mode
    slave = 1'b1; p_hs = 1'b0; p_vs = 1'b0; p_bl = 1'b0; p_fd = 1'b0;
    hs_i = 1'b0; vs_i = 1'b0; blank_i = 1'b0; hs_on = 1'b1;
    do_reset();
    @(negedge clk);
    chk("R4 drive slave", int'(drive_o), 0);
    repeat (30) @(negedge clk);
    chk("R7 parked pix", int'(pix), LL - 1);

    pulse(0, 1);
    chk("R8 vs line", int'(line), 0);
    chk("R8 vs field", int'(field_o), 1);
    repeat (20) @(negedge clk);

    // early / on-time / late line table
    pulse(1, 0);
    repeat (HTAB[0].gap - 4) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      string rq;
      rq = (HTAB[k].gap < LL) ? "R6 early line" : "R7 late line";
      pulse(1, 0);
      chk(rq, last_len, HTAB[k].len);
      chk({rq, " hold"}, last_hold, HTAB[k].hold);
      chk("R7 hold level", last_bad, 0);
      repeat (((k < 5) ? HTAB[k + 1].gap : 24) - 4) @(negedge clk);
    end

    // late field: line 7 -> 10 (last of even field), then held
    hpulses(3);
    chk("R3 last even line", int'(line), EVEN - 1);
    pulse(1, 0);
    chk("R9 held line", int'(line), EVEN - 1);
    repeat (20) @(negedge clk);
    pulse(1, 0);
    chk("R9 held line", int'(line), EVEN - 1);
    repeat (8) @(negedge clk);
    chk("R9 hold level", int'(level), 2);
    repeat (12) @(negedge clk);
    pulse(0, 1);
    chk("R9 release line", int'(line), 0);
    chk("R9 release field", int'(field_o), 0);
    repeat (20) @(negedge clk);

    // early field
    hpulses(3);
    chk("R6 line advance", int'(line), 3);
    pulse(0, 1);
    chk("R8 early line", int'(line), 0);
    chk("R8 early field", int'(field_o), 1);
    repeat (20) @(negedge clk);

    // active level and external blank
    hpulses(2);
    pulse(1, 0);
    repeat (8) @(negedge clk);
    chk("R5 active", int'(level), 0);
    blank_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 ext blank", int'(level), 2);
    blank_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 released", int'(level), 0);
    repeat (6) @(negedge clk);

    // coincident horizontal and vertical edges
    chk("R10 line before", int'(line), 3);
    pulse(1, 1);
    chk("R10 line", int'(line), 0);
    chk("R10 pix", int'(pix), 1);
    chk("R10 field", int'(field_o), 0);
    repeat (20) @(negedge clk);

    // active-low horizontal input
    p_hs = 1'b1; hs_on = 1'b0; hs_i = 1'b1;
    do_reset();
    repeat (30) @(negedge clk);
    chk("R7 parked low pol", int'(pix), LL - 1);
    pulse(1, 0);
    chk("R12 line", int'(line), 1);
    chk("R12 pix", int'(pix), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule